// File: doc/BRIEF.md
# Serial Channel Configuration Sequencer

This block converts a 16-bit line-setup word into the register values for one channel of a dual-channel serial controller. It then programs that channel over a byte-wide command port. The setup word gives the character length, the stop-bit count and the parity. A separate input gives the requested baud rate as a multiple of 75 (baud/75). A third input gives the controller clock already scaled down by 32 and by 75. From these two inputs a sequential restoring divider derives the baud generator divisor. The value actually programmed is that divisor minus two.

Once the divisor is known, the sequencer resets the selected channel. It then writes the register list in a fixed order. Every write takes two byte transfers on the command port: first the register number, then the value. A start request that cannot be met is rejected: the divisor would fall below two, or the baud quotient is zero. In that case the block writes nothing and leaves its stored configuration as it was. A setup word of all ones asks the block to re-apply the configuration it last stored. After reset that stored configuration is the failsafe one: 8 data bits, 1 stop bit, no parity, and a baud quotient of 512.

Top module: `serial_cfg_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `fail` and `cmd_wr` are all low.
- R2: Each register write is two accepted byte transfers, register number first and value second. The first write of every sequence is register 9 with value 0x80 when `chan_sel`=0 (channel A) or 0x40 when `chan_sel`=1 (channel B).
- R3: After the reset write, the registers follow in exactly this order: 4, 1, 2, 3, 5, 11, 12, 13, 14, 14, 3, 5, 9. The values written with default parameters are:
  - register 1: 0x00
  - register 2: 0x00
  - register 11: 0x56
  - first write of register 14: 0x00
  - second write of register 14: 0x01
  - register 9 (last write): 0x00
- R4: The setup word's length field is bits 1:0, meaning 00=5, 01=6, 10=7 and 11=8 data bits. The controller code is 5→00, 6→10, 7→01, 8→11. This code is placed in bits 7:6 of the first register-3 value (all other bits 0). It is also placed in bits 6:5 of the first register-5 value (other bits 0x82). The final register-3 write adds bit 0 and the final register-5 write adds bit 3.
- R5: The register-4 value is 0x40 with three groups of bits added:
  - stop bits: bits 3:2 are 01 when setup bit 2 is 0 (one stop bit) and 11 when it is 1 (two stop bits);
  - bit 0: copies setup bit 3 (parity enable);
  - bit 1: copies setup bit 4 (even parity).
- R6: With D = floor(`clk_quot` / baud quotient), register 12 receives the low byte of D−2 and register 13 receives the high byte.
- R7: If the baud quotient is zero or D < 2, the block issues no byte transfer at all. It ends with `done` and `fail` high together, and the stored configuration is left unchanged. `fail` is never high without `done`.
- R8: A setup word of 0xFFFF makes the block use the stored setup word and the stored baud quotient, and ignore `baud_quot`. Each successful sequence replaces the stored pair with the pair it used.
- R9: After reset the stored configuration is setup word 0x0003 and baud quotient 512. With `clk_quot`=2048 this gives a programmed divisor of 2 (register 12 = 0x02, register 13 = 0x00).
- R10: A byte transfers only in a cycle where both `cmd_wr` and `cmd_ready` are high. While `cmd_wr` is high and `cmd_ready` is low, `cmd_wr` stays high and `cmd_data` does not change in the next cycle.
- R11: `busy` rises in the cycle after a start is accepted and stays high until the cycle in which `done` is high. A `start` pulse that arrives while `busy` is high has no effect. `cmd_wr` is never high while `busy` is low.
- R12: Each accepted start produces exactly one `done` pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a configuration run; sampled only when idle |
| chan_sel | input | 1 | Channel to program: 0 = A, 1 = B |
| setup_word | input | 16 | Line-setup word; 0xFFFF re-applies the stored setup |
| baud_quot | input | 16 | Requested baud rate divided by 75 |
| clk_quot | input | 16 | Controller clock divided by 32 and by 75 |
| cmd_ready | input | 1 | Command port accepts a byte this cycle |
| cmd_wr | output | 1 | Command port byte valid |
| cmd_data | output | 8 | Register number or register value |
| busy | output | 1 | Sequence (including division) in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | With `done`: request rejected, nothing written |

## Verification
The bench covers all four data lengths, because a design that put the setup bits straight into the controller field, instead of swapping them, would write 6 and 7 bits the wrong way round. It drives a divisor of exactly two and a divisor of one. An off-by-one in the range check would either reject the legal zero divisor or program a wrapped 0xFFFF into registers 12 and 13. After a rejected run it re-applies the stored setup. A design that committed the setup before its check would then stream the rejected values. It also sends a second start while a run is busy, stalls the port at different rates, and uses a high divisor byte. These catch a sequencer that restarts mid-run, drops or changes a byte under back-pressure, or mixes up the two divisor bytes.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  localparam int SETUP_W   = 16;
  localparam int BYTE_W    = 8;
  localparam int NUM_STEPS = 14;

  localparam logic [7:0] CR_INTEN   = 8'd1;
  localparam logic [7:0] CR_VECTOR  = 8'd2;
  localparam logic [7:0] CR_RXCTL   = 8'd3;
  localparam logic [7:0] CR_MODE    = 8'd4;
  localparam logic [7:0] CR_TXCTL   = 8'd5;
  localparam logic [7:0] CR_MASTER  = 8'd9;
  localparam logic [7:0] CR_CLKMAP  = 8'd11;
  localparam logic [7:0] CR_BRG_LO  = 8'd12;
  localparam logic [7:0] CR_BRG_HI  = 8'd13;
  localparam logic [7:0] CR_BRG_CTL = 8'd14;

  localparam logic [7:0] RST_CHAN_A = 8'h80;
  localparam logic [7:0] RST_CHAN_B = 8'h40;

  typedef struct packed {
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] val;
  } reg_pair_t;

  // controller length code: the two setup bits swapped
  function automatic logic [1:0] len_code(input logic [1:0] fld);
    return {fld[0], fld[1]};
  endfunction

  // async x16 base; bit 2 always set, bit 3 added for two stop bits
  function automatic logic [7:0] mode_value(input logic [7:0] lo);
    logic [7:0] r;
    r    = 8'h44;
    r[3] = lo[2];
    r[0] = lo[3];
    r[1] = lo[4];
    return r;
  endfunction

  function automatic logic [7:0] rx_value(input logic [1:0] code);
    return {code, 6'b000000};
  endfunction

  function automatic logic [7:0] tx_value(input logic [1:0] code);
    return 8'h82 | {1'b0, code, 5'b00000};
  endfunction

endpackage

// File: rtl/cfg_restoring_div.sv
module cfg_restoring_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         valid,
  output logic [W-1:0] quo
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem, den_l, num_l;
  logic [CNT_W-1:0] cnt;
  logic [W:0]       shifted, trial;

  always_comb begin
    shifted = {rem, quo[W-1]};
    trial   = shifted - {1'b0, den_l};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      quo   <= '0;
      den_l <= '0;
      num_l <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (start && !busy) begin
        rem   <= '0;
        quo   <= num;
        den_l <= den;
        num_l <= num;
        cnt   <= CNT_W'(W);
        busy  <= 1'b1;
      end else if (busy) begin
        if (!trial[W]) begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= shifted[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          busy  <= 1'b0;
          valid <= 1'b1;
        end
      end
    end
  end

  logic [2*W-1:0] prod_chk, num_chk, den_chk;
  always_comb begin
    num_chk  = {{W{1'b0}}, num_l};
    den_chk  = {{W{1'b0}}, den_l};
    prod_chk = {{W{1'b0}}, quo} * den_chk;
  end

  // R6: the quotient is the exact floor of the division
  p_div_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && den_l != '0) |-> (prod_chk <= num_chk) && ((num_chk - prod_chk) < den_chk));

endmodule

// File: rtl/cfg_step_table.sv
module cfg_step_table
  import serial_cfg_pkg::*;
#(
  parameter logic [7:0] INTEN_VAL  = 8'h00,
  parameter logic [7:0] VECTOR_VAL = 8'h00,
  parameter logic [7:0] MASTER_VAL = 8'h00,
  parameter logic [7:0] CLKMAP_VAL = 8'h56,
  parameter logic [7:0] BRGSRC_VAL = 8'h00,
  parameter int         STEP_W     = 4
) (
  input  logic [STEP_W-1:0] idx,
  input  logic              chan_b,
  input  logic [7:0]        mode_v,
  input  logic [7:0]        rx_v,
  input  logic [7:0]        tx_v,
  input  logic [15:0]       brg_v,
  output reg_pair_t         pair
);
  always_comb begin
    pair = '0;
    case (idx)
      STEP_W'(0):  pair = '{CR_MASTER,  chan_b ? RST_CHAN_B : RST_CHAN_A};
      STEP_W'(1):  pair = '{CR_MODE,    mode_v};
      STEP_W'(2):  pair = '{CR_INTEN,   INTEN_VAL};
      STEP_W'(3):  pair = '{CR_VECTOR,  VECTOR_VAL};
      STEP_W'(4):  pair = '{CR_RXCTL,   rx_v};
      STEP_W'(5):  pair = '{CR_TXCTL,   tx_v};
      STEP_W'(6):  pair = '{CR_CLKMAP,  CLKMAP_VAL};
      STEP_W'(7):  pair = '{CR_BRG_LO,  brg_v[7:0]};
      STEP_W'(8):  pair = '{CR_BRG_HI,  brg_v[15:8]};
      STEP_W'(9):  pair = '{CR_BRG_CTL, BRGSRC_VAL};
      STEP_W'(10): pair = '{CR_BRG_CTL, BRGSRC_VAL | 8'h01};
      STEP_W'(11): pair = '{CR_RXCTL,   rx_v | 8'h01};
      STEP_W'(12): pair = '{CR_TXCTL,   tx_v | 8'h08};
      STEP_W'(13): pair = '{CR_MASTER,  MASTER_VAL};
      default:     pair = '0;
    endcase
  end
endmodule

// File: rtl/cfg_port_writer.sv
module cfg_port_writer
  import serial_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  reg_pair_t  pair,
  input  logic       cmd_ready,
  output logic       cmd_wr,
  output logic [7:0] cmd_data,
  output logic       pair_done
);
  typedef enum logic [1:0] {W_IDLE, W_ADDR, W_VAL} wstate_t;

  wstate_t   st;
  reg_pair_t held;

  assign cmd_wr   = (st != W_IDLE);
  assign cmd_data = (st == W_VAL) ? held.val : held.addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      held      <= '0;
      pair_done <= 1'b0;
    end else begin
      pair_done <= 1'b0;
      case (st)
        W_IDLE: if (go) begin
          held <= pair;
          st   <= W_ADDR;
        end
        W_ADDR: if (cmd_ready) st <= W_VAL;
        W_VAL:  if (cmd_ready) begin
          st        <= W_IDLE;
          pair_done <= 1'b1;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  // R10: a stalled byte is held unchanged
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_ready) |=> (cmd_wr && $stable(cmd_data)));

  // R2: a pair completes only after its value byte was accepted
  p_pair_after_val_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |-> $past(cmd_wr && cmd_ready));

endmodule

// File: rtl/serial_cfg_seq.sv
module serial_cfg_seq
  import serial_cfg_pkg::*;
#(
  parameter int          QUOT_W     = 16,
  parameter logic [15:0] DEF_SETUP  = 16'h0003,
  parameter int          DEF_BAUDQ  = 512,
  parameter logic [7:0]  INTEN_VAL  = 8'h00,
  parameter logic [7:0]  VECTOR_VAL = 8'h00,
  parameter logic [7:0]  MASTER_VAL = 8'h00,
  parameter logic [7:0]  CLKMAP_VAL = 8'h56,
  parameter logic [7:0]  BRGSRC_VAL = 8'h00
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               chan_sel,
  input  logic [SETUP_W-1:0] setup_word,
  input  logic [QUOT_W-1:0]  baud_quot,
  input  logic [QUOT_W-1:0]  clk_quot,
  input  logic               cmd_ready,
  output logic               cmd_wr,
  output logic [7:0]         cmd_data,
  output logic               busy,
  output logic               done,
  output logic               fail
);
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [SETUP_W-1:0] REUSE_WORD = '1;

  typedef enum logic [2:0] {S_IDLE, S_DIV, S_WAIT, S_SEND, S_PAIR} state_t;

  state_t              state;
  logic [SETUP_W-1:0]  cur_word, stored_word;
  logic [QUOT_W-1:0]   cur_bq, cur_cq, stored_bq;
  logic                cur_chan;
  logic [STEP_W-1:0]   step_idx;
  logic [15:0]         prog_div;

  // named internal events
  logic              div_start, div_busy, div_valid;
  logic [QUOT_W-1:0] div_q;
  logic              cfg_reject, cfg_accept;
  logic              wr_go, pair_done;
  reg_pair_t         step_pair;
  logic [1:0]        code;
  logic [7:0]        mode_v, rx_v, tx_v;

  assign busy       = (state != S_IDLE);
  assign div_start  = (state == S_DIV);
  assign wr_go      = (state == S_SEND);
  assign cfg_reject = div_valid && ((cur_bq == '0) || (div_q < QUOT_W'(2)));
  assign cfg_accept = div_valid && !cfg_reject;

  always_comb begin
    code   = len_code(cur_word[1:0]);
    mode_v = mode_value(cur_word[7:0]);
    rx_v   = rx_value(code);
    tx_v   = tx_value(code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cur_word    <= '0;
      cur_bq      <= '0;
      cur_cq      <= '0;
      cur_chan    <= 1'b0;
      stored_word <= DEF_SETUP;
      stored_bq   <= QUOT_W'(DEF_BAUDQ);
      step_idx    <= '0;
      prog_div    <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (setup_word == REUSE_WORD) begin
            cur_word <= stored_word;
            cur_bq   <= stored_bq;
          end else begin
            cur_word <= setup_word;
            cur_bq   <= baud_quot;
          end
          cur_cq   <= clk_quot;
          cur_chan <= chan_sel;
          state    <= S_DIV;
        end
        S_DIV: state <= S_WAIT;
        S_WAIT: begin
          if (cfg_reject) begin
            done  <= 1'b1;
            fail  <= 1'b1;
            state <= S_IDLE;
          end else if (cfg_accept) begin
            prog_div    <= 16'(div_q - QUOT_W'(2));
            stored_word <= cur_word;
            stored_bq   <= cur_bq;
            step_idx    <= '0;
            state       <= S_SEND;
          end
        end
        S_SEND: state <= S_PAIR;
        S_PAIR: if (pair_done) begin
          if (step_idx == LAST_STEP) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            step_idx <= step_idx + 1'b1;
            state    <= S_SEND;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  cfg_restoring_div #(.W(QUOT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (div_start),
    .num   (cur_cq),
    .den   (cur_bq),
    .busy  (div_busy),
    .valid (div_valid),
    .quo   (div_q)
  );

  cfg_step_table #(
    .INTEN_VAL  (INTEN_VAL),
    .VECTOR_VAL (VECTOR_VAL),
    .MASTER_VAL (MASTER_VAL),
    .CLKMAP_VAL (CLKMAP_VAL),
    .BRGSRC_VAL (BRGSRC_VAL),
    .STEP_W     (STEP_W)
  ) u_table (
    .idx    (step_idx),
    .chan_b (cur_chan),
    .mode_v (mode_v),
    .rx_v   (rx_v),
    .tx_v   (tx_v),
    .brg_v  (prog_div),
    .pair   (step_pair)
  );

  cfg_port_writer u_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (wr_go),
    .pair      (step_pair),
    .cmd_ready (cmd_ready),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .pair_done (pair_done)
  );

  // R12: done is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: fail only accompanies done
  p_fail_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

  // R7: a rejected request leaves the stored setup untouched
  p_keep_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> ($stable(stored_word) && $stable(stored_bq)));

  // R11: no port traffic outside a run
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_wr);

  // R6: nothing is written before the divisor is known
  p_div_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !cmd_wr);

endmodule

// File: tb/serial_cfg_seq_bench.sv
module serial_cfg_seq_bench;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        chan_sel = 1'b0;
  logic [15:0] setup_word = '0;
  logic [15:0] baud_quot = '0;
  logic [15:0] clk_quot = '0;
  logic        cmd_ready = 1'b1;
  logic        cmd_wr;
  logic [7:0]  cmd_data;
  logic        busy, done, fail;

  int tests = 0;
  int fails = 0;
  int ready_mode = 0;
  int rdy_cnt = 0;
  int xfer_cnt = 0;
  int done_cnt = 0;
  int cycles = 0;
  bit last_fail = 1'b0;
  bit prev_done = 1'b0;
  bit prev_stall = 1'b0;
  logic [7:0] prev_data = '0;
  bit finished = 1'b0;

  logic [15:0] st_word = 16'h0003;
  logic [15:0] st_bq = 16'd512;

  exp_t q_exp[$];

  always #4 clk = ~clk;

  serial_cfg_seq u_serial_cfg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .setup_word(setup_word), .baud_quot(baud_quot), .clk_quot(clk_quot),
    .cmd_ready(cmd_ready), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .busy(busy), .done(done), .fail(fail)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s got %0h exp %0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    rdy_cnt <= rdy_cnt + 1;
    case (ready_mode)
      0:       cmd_ready <= 1'b1;
      1:       cmd_ready <= rdy_cnt[0];
      default: cmd_ready <= (rdy_cnt % 3 == 0);
    endcase
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        done_cnt++;
        last_fail = fail;
        if (prev_done) check(1'b0, "R12", "done wider than one cycle", 1, 0);
      end
      if (fail && !done) check(1'b0, "R7", "fail without done", 1, 0);
      if (prev_stall)
        check(cmd_wr && cmd_data == prev_data, "R10", "stalled byte changed",
              {cmd_wr, cmd_data}, {1'b1, prev_data});
      if (cmd_wr && cmd_ready) begin
        xfer_cnt++;
        if (q_exp.size() == 0) begin
          check(1'b0, "R7", "unexpected byte", cmd_data, 0);
        end else begin
          exp_t e;
          e = q_exp.pop_front();
          check(cmd_data == e.v, e.tag, "port byte", cmd_data, e.v);
        end
      end
      prev_done  = done;
      prev_stall = cmd_wr && !cmd_ready;
      prev_data  = cmd_data;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: run hung, got %0d exp %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  function automatic logic [1:0] bench_code(input logic [1:0] fld);
    int bits;
    bits = 5 + fld;
    if (bits == 5) return 2'd0;
    else if (bits == 6) return 2'd2;
    else if (bits == 7) return 2'd1;
    else return 2'd3;
  endfunction

  task automatic push(input logic [7:0] a, input logic [7:0] v, input string tag);
    exp_t e;
    e.v = a; e.tag = "R3"; q_exp.push_back(e);
    e.v = v; e.tag = tag;  q_exp.push_back(e);
  endtask

  task automatic push_stream(input logic [15:0] w, input logic [15:0] dv, input bit ch);
    logic [1:0] c;
    logic [7:0] m, r3, r5;
    c  = bench_code(w[1:0]);
    m  = 8'd64 + 8'd4 + (w[2] ? 8'd8 : 8'd0) + (w[3] ? 8'd1 : 8'd0) + (w[4] ? 8'd2 : 8'd0);
    r3 = 8'(c * 64);
    r5 = 8'(8'h82 + c * 32);
    push(8'd9,  ch ? 8'h40 : 8'h80, "R2");
    push(8'd4,  m, "R5");
    push(8'd1,  8'h00, "R3");
    push(8'd2,  8'h00, "R3");
    push(8'd3,  r3, "R4");
    push(8'd5,  r5, "R4");
    push(8'd11, 8'h56, "R3");
    push(8'd12, dv[7:0], "R6");
    push(8'd13, dv[15:8], "R6");
    push(8'd14, 8'h00, "R3");
    push(8'd14, 8'h01, "R3");
    push(8'd3,  r3 + 8'd1, "R4");
    push(8'd5,  r5 + 8'd8, "R4");
    push(8'd9,  8'h00, "R3");
  endtask

  task automatic run_op(input logic [15:0] w, input logic [15:0] bq,
                        input logic [15:0] cq, input bit ch, input bit poke);
    logic [15:0] ew, eb;
    int d, xb, db, guard;
    bit ef;
    ew = (w == 16'hFFFF) ? st_word : w;
    eb = (w == 16'hFFFF) ? st_bq : bq;
    ef = (eb == 0);
    d  = ef ? 0 : int'(cq) / int'(eb);
    if (d < 2) ef = 1'b1;
    if (!ef) push_stream(ew, 16'(d - 2), ch);
    xb = xfer_cnt;
    db = done_cnt;
    @(negedge clk);
    setup_word = w; baud_quot = bq; clk_quot = cq; chan_sel = ch; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R11", "busy after start", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      setup_word = 16'h0000; baud_quot = 16'd1; chan_sel = ~ch; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (done_cnt == db && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    check(done_cnt == db + 1, "R12", "done count", done_cnt - db, 1);
    check(last_fail == ef, ef ? "R7" : "R6", "fail flag", last_fail, ef);
    check(busy == 1'b0, "R11", "busy at done", busy, 0);
    check(q_exp.size() == 0, "R3", "bytes still expected", q_exp.size(), 0);
    if (ef) check(xfer_cnt == xb, "R7", "bytes on reject", xfer_cnt - xb, 0);
    else begin
      st_word = ew;
      st_bq   = eb;
    end
    if (poke) begin
      repeat (60) @(negedge clk);
      check(done_cnt == db + 1, "R11", "start while busy ran", done_cnt - db, 1);
    end
    q_exp.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(!busy && !done && !fail && !cmd_wr, "R1", "outputs in reset",
          {busy, done, fail, cmd_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fail && !cmd_wr, "R1", "outputs after reset",
          {busy, done, fail, cmd_wr}, 0);

    // R9 / R8: failsafe stored setup, baud input ignored
    run_op(16'hFFFF, 16'd7, 16'd2048, 1'b0, 1'b0);
    // 8 bits, two stop, even parity, channel B, stalled port
    ready_mode = 1;
    run_op(16'h001F, 16'd128, 16'd2048, 1'b1, 1'b0);
    // 7 bits, odd parity, large divisor (high byte used)
    ready_mode = 2;
    run_op(16'h050A, 16'd1, 16'd2048, 1'b0, 1'b0);
    // 5 bits and 6 bits
    ready_mode = 0;
    run_op(16'h0000, 16'd16, 16'd2048, 1'b1, 1'b0);
    run_op(16'h0001, 16'd16, 16'd2048, 1'b0, 1'b0);
    // R7: divisor of one rejected, then stored setup re-applied
    run_op(16'h0013, 16'd2048, 16'd2048, 1'b0, 1'b0);
    run_op(16'hFFFF, 16'd3, 16'd2048, 1'b1, 1'b0);
    // R7: zero baud quotient rejected
    run_op(16'h0002, 16'd0, 16'd2048, 1'b0, 1'b0);
    // R6: exact divisor of two programs zero
    ready_mode = 1;
    run_op(16'h0006, 16'd1024, 16'd2048, 1'b1, 1'b0);
    // R11: start while busy ignored
    run_op(16'h0003, 16'd64, 16'd2048, 1'b0, 1'b1);
    run_op(16'hFFFF, 16'd9, 16'd2048, 1'b1, 1'b0);

    repeat (5) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule